// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block holds the programmed burst settings of a synchronous DRAM and produces the column address for each data beat of a read or write. A controller loads a 12-bit mode word whenever it programs the memory's mode. The block decodes the burst length, the beat ordering, the CAS latency and the write-burst policy from that word. Any load that carries an unsupported encoding leaves the previous settings in force and raises a sticky error flag.

Each command-start pulse carries an 8-bit starting column and a read/write flag. From the next cycle on, `colOut` presents the column of the current beat and `colValid` is high. Every `advance` pulse moves the burst to its next beat. For bursts of 2, 4 or 8 beats, the column stays inside the aligned block that holds the starting column. The order is either a wrapping increment or the start position XORed with the beat index. A full-page burst increments through the 256-column row with wrap-around and runs until `terminate` is pulsed. `lastBeat` marks the final beat of a burst of fixed length. A new command-start always takes precedence and restarts the sequence.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, colValid, lastBeat and modeErr are 0 and casLat reads 2. The burst length is 1, the ordering is sequential and writes use the programmed length.
- R2: A legal mode load takes effect for later commands. Mode-word fields: bits 2..0 give the length (000=1, 001=2, 010=4, 011=8, 111=full page). Bit 3 gives the order (0 sequential, 1 interleaved). Bits 6..4 give the CAS latency (010=2, 011=3). Bits 8..7 must be 00. Bit 9 set to 1 forces single writes. Bits 11..10 must be 00. casLat shows the loaded latency as 2 or 3.
- R3: A load with a reserved length code, a CAS code other than 010 or 011, nonzero bits 8..7 or 11..10, or full page together with interleaved order sets modeErr. modeErr then stays set until reset, and the previous settings remain in force.
- R4: One cycle after cmdStart, colValid is 1 and colOut equals cmdCol (beat 0). A cmdStart during an active burst abandons that burst.
- R5: For lengths 2, 4 and 8 in sequential order, beat k uses block position (start+k) mod L. The column bits above the block stay unchanged.
- R6: For lengths 2, 4 and 8 in interleaved order, beat k uses block position start XOR k. The column bits above the block stay unchanged.
- R7: With length 1, only the starting column is produced, lastBeat is high on beat 0, and the order bit has no effect.
- R8: A full-page burst increments the column and wraps from 255 to 0. It never raises lastBeat and continues until terminate, after which colValid is 0.
- R9: When bit 9 is 1, a write command yields a one-beat burst, while a read command still uses the programmed length.
- R10: lastBeat is high exactly on beat L-1. An advance on that beat clears colValid, unless cmdStart arrives in the same cycle, in which case the new burst starts at once.
- R11: While no advance, cmdStart or terminate arrives, colOut, colValid and lastBeat hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeLoad | input | 1 | Strobe that loads modeWord |
| modeWord | input | 12 | Mode word to decode |
| cmdStart | input | 1 | Starts a burst |
| cmdCol | input | 8 | Starting column of the burst |
| cmdWrite | input | 1 | 1 for a write command, 0 for a read |
| advance | input | 1 | Consumes the current beat |
| terminate | input | 1 | Ends the active burst |
| colOut | output | 8 | Column of the current beat |
| colValid | output | 1 | A burst beat is present |
| lastBeat | output | 1 | Current beat is the final one |
| casLat | output | 2 | Decoded CAS latency (2 or 3) |
| modeErr | output | 1 | Sticky illegal-mode flag |

## Verification
The bench aims at wrap-around inside an aligned block, using starting columns in the middle of a block whose upper column bits are not zero. A design that carried the wrap into the upper bits would move the burst into the wrong block. Interleaved bursts that start at odd positions would expose a sequential adder used where an XOR belongs. Full-page bursts that start near column 255 show whether the design wraps to 0 or stops early. Illegal loads are followed by bursts and a casLat readback, which reveals a design that partly adopted the bad word. Back-to-back commands placed on the last beat and in mid-burst catch a design that drops the new burst or keeps the old beat count.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MODE_W = 12;

  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;

  localparam logic [2:0] CAS_TWO   = 3'b010;
  localparam logic [2:0] CAS_THREE = 3'b011;

  typedef struct packed {
    logic [2:0] lenCode;
    logic       interleave;
    logic       casThree;
    logic       wbSingle;
  } modeCfg_t;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/bcs_mode_dec.sv
module bcs_mode_dec
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  output modeCfg_t          cfg,
  output logic              modeErr
);
  localparam int LEN_LO  = 0;
  localparam int TYPE_B  = 3;
  localparam int CAS_LO  = 4;
  localparam int OP_LO   = 7;
  localparam int WB_B    = 9;
  localparam int RSV_LO  = 10;

  logic [2:0] lenField;
  logic [2:0] casField;
  logic       lenOk;
  logic       casOk;
  logic       opOk;
  logic       rsvOk;
  logic       comboOk;
  logic       legal;
  modeCfg_t   nextCfg;

  always_comb begin
    lenField = modeWord[LEN_LO +: 3];
    casField = modeWord[CAS_LO +: 3];
    lenOk    = (lenField == LEN_ONE) || (lenField == LEN_TWO) ||
               (lenField == LEN_FOUR) || (lenField == LEN_EIGHT) ||
               (lenField == LEN_PAGE);
    casOk    = (casField == CAS_TWO) || (casField == CAS_THREE);
    opOk     = (modeWord[OP_LO +: 2] == 2'b00);
    rsvOk    = (modeWord[RSV_LO +: 2] == 2'b00);
    comboOk  = !((lenField == LEN_PAGE) && modeWord[TYPE_B]);
    legal    = lenOk && casOk && opOk && rsvOk && comboOk;

    nextCfg.lenCode    = lenField;
    nextCfg.interleave = modeWord[TYPE_B];
    nextCfg.casThree   = (casField == CAS_THREE);
    nextCfg.wbSingle   = modeWord[WB_B];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg.lenCode    <= LEN_ONE;
      cfg.interleave <= 1'b0;
      cfg.casThree   <= 1'b0;
      cfg.wbSingle   <= 1'b0;
      modeErr        <= 1'b0;
    end else if (modeLoad) begin
      if (legal) begin
        cfg <= nextCfg;
      end else begin
        modeErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       advance,
  input  logic       terminate,
  input  logic       atLast,
  output seqStrobe_t strobe,
  output logic       colValid,
  output logic       lastBeat
);
  logic active;

  always_comb begin
    strobe.load = cmdStart;
    strobe.step = advance && active && !atLast && !cmdStart;
    colValid    = active;
    lastBeat    = active && atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
    end else if (cmdStart) begin
      active <= 1'b1;
    end else if (terminate) begin
      active <= 1'b0;
    end else if (advance && active && atLast) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/bcs_dp.sv
module bcs_dp
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] cmdCol,
  input  logic             cmdWrite,
  input  modeCfg_t         cfg,
  output logic [COL_W-1:0] colOut,
  output logic             atLast
);
  localparam logic [COL_W-1:0] ONE_BEAT = COL_W'(1);

  function automatic logic [COL_W-1:0] lenMask(input logic [2:0] code);
    case (code)
      LEN_ONE:   lenMask = '0;
      LEN_TWO:   lenMask = COL_W'(1);
      LEN_FOUR:  lenMask = COL_W'(3);
      LEN_EIGHT: lenMask = COL_W'(7);
      default:   lenMask = '1;
    endcase
  endfunction

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatIdx;
  logic [COL_W-1:0] blkMask;
  logic             pageMode;
  logic             xorOrder;
  logic             singleWr;
  logic [COL_W-1:0] offsSeq;
  logic [COL_W-1:0] offsXor;
  logic [COL_W-1:0] offs;

  assign singleWr = cmdWrite && cfg.wbSingle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol  <= '0;
      beatIdx  <= '0;
      blkMask  <= '0;
      pageMode <= 1'b0;
      xorOrder <= 1'b0;
    end else if (strobe.load) begin
      baseCol  <= cmdCol;
      beatIdx  <= '0;
      blkMask  <= singleWr ? '0 : lenMask(cfg.lenCode);
      pageMode <= !singleWr && (cfg.lenCode == LEN_PAGE);
      xorOrder <= !singleWr && cfg.interleave;
    end else if (strobe.step) begin
      beatIdx <= beatIdx + ONE_BEAT;
    end
  end

  always_comb begin
    offsSeq = baseCol + beatIdx;
    offsXor = baseCol ^ beatIdx;
    offs    = xorOrder ? offsXor : offsSeq;
    colOut  = (baseCol & ~blkMask) | (offs & blkMask);
    atLast  = !pageMode && (beatIdx == blkMask);
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeLoad,
  input  logic [11:0] modeWord,
  input  logic        cmdStart,
  input  logic [7:0]  cmdCol,
  input  logic        cmdWrite,
  input  logic        advance,
  input  logic        terminate,
  output logic [7:0]  colOut,
  output logic        colValid,
  output logic        lastBeat,
  output logic [1:0]  casLat,
  output logic        modeErr
);
  modeCfg_t   cfg;
  seqStrobe_t strobe;
  logic       atLast;

  bcs_mode_dec u_mode (
    .clk      (clk),
    .rstN     (rstN),
    .modeLoad (modeLoad),
    .modeWord (modeWord),
    .cfg      (cfg),
    .modeErr  (modeErr)
  );

  bcs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStart  (cmdStart),
    .advance   (advance),
    .terminate (terminate),
    .atLast    (atLast),
    .strobe    (strobe),
    .colValid  (colValid),
    .lastBeat  (lastBeat)
  );

  bcs_dp #(.COL_W(8)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdCol   (cmdCol),
    .cmdWrite (cmdWrite),
    .cfg      (cfg),
    .colOut   (colOut),
    .atLast   (atLast)
  );

  assign casLat = cfg.casThree ? 2'd3 : 2'd2;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       modeLoad,
  input logic       cmdStart,
  input logic       advance,
  input logic       terminate,
  input logic [7:0] colOut,
  input logic       colValid,
  input logic       lastBeat,
  input logic [1:0] casLat,
  input logic       modeErr
);
  // R10: the final-beat marker only appears inside a burst
  a_r10_last_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  // R4: a command always yields a valid beat next cycle
  a_r4_start_valid: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> colValid);

  // R3: the error flag never clears without reset
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> modeErr);

  // R8: terminate ends any burst
  a_r8_terminate: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !cmdStart) |=> !colValid);

  // R10: advancing on the last beat ends the burst
  a_r10_end: assert property (@(posedge clk) disable iff (!rstN)
    (advance && lastBeat && !cmdStart && !terminate) |=> !colValid);

  // R11: idle cycles hold the beat
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !advance && !cmdStart && !terminate) |=>
      ($stable(colOut) && colValid && $stable(lastBeat)));

  // R2: CAS latency only changes on a load
  a_r2_cas_stable: assert property (@(posedge clk) disable iff (!rstN)
    !modeLoad |=> $stable(casLat));

  // R2: casLat only ever reads 2 or 3
  a_r2_cas_range: assert property (@(posedge clk) disable iff (!rstN)
    casLat[1]);
endmodule

bind burst_col_seq bcs_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeLoad  (modeLoad),
  .cmdStart  (cmdStart),
  .advance   (advance),
  .terminate (terminate),
  .colOut    (colOut),
  .colValid  (colValid),
  .lastBeat  (lastBeat),
  .casLat    (casLat),
  .modeErr   (modeErr)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeLoad = 1'b0;
  logic [11:0] modeWord = '0;
  logic        cmdStart = 1'b0;
  logic [7:0]  cmdCol = '0;
  logic        cmdWrite = 1'b0;
  logic        advance = 1'b0;
  logic        terminate = 1'b0;
  logic [7:0]  colOut;
  logic        colValid;
  logic        lastBeat;
  logic [1:0]  casLat;
  logic        modeErr;

  int checks = 0;
  int failures = 0;

  // bench model of the settings
  logic [2:0] mLen = 3'b000;
  logic       mInter = 1'b0;
  logic [1:0] mCas = 2'd2;
  logic       mWb = 1'b0;

  burst_col_seq u_dut (.*);

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish (act=hung exp=done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] code);
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] expCol(input logic [7:0] s, input int k, input int len, input bit inter);
    logic [7:0] msk;
    logic [7:0] pos;
    logic [7:0] kk;
    kk = 8'(k);
    if (len == 0) return s + kk;
    msk = 8'(len - 1);
    pos = inter ? ((s ^ kk) & msk) : ((s + kk) & msk);
    return (s & ~msk) | pos;
  endfunction

  function automatic bit legalWord(input logic [11:0] w);
    bit ok;
    ok = (w[2:0] <= 3'b011) || (w[2:0] == 3'b111);
    ok = ok && ((w[6:4] == 3'b010) || (w[6:4] == 3'b011));
    ok = ok && (w[8:7] == 2'b00) && (w[11:10] == 2'b00);
    ok = ok && !((w[2:0] == 3'b111) && w[3]);
    return ok;
  endfunction

  task automatic loadMode(input logic [11:0] w);
    modeLoad = 1'b1;
    modeWord = w;
    tick();
    modeLoad = 1'b0;
    if (legalWord(w)) begin
      mLen = w[2:0];
      mInter = w[3];
      mCas = (w[6:4] == 3'b011) ? 2'd3 : 2'd2;
      mWb = w[9];
    end
  endtask

  // start a burst, step through every beat and check each one
  task automatic runBurst(input logic [7:0] s, input bit wr, input int gapMax, input string req);
    int len;
    int n;
    bit ip;
    len = (wr && mWb) ? 1 : lenOf(mLen);
    ip = (len > 1) && mInter;
    n = (len == 0) ? 20 : len;
    cmdStart = 1'b1;
    cmdCol = s;
    cmdWrite = wr;
    tick();
    cmdStart = 1'b0;
    for (int k = 0; k < n; k++) begin
      int gap;
      gap = (gapMax > 0) ? int'($urandom_range(gapMax, 0)) : 0;
      for (int g = 0; g <= gap; g++) begin
        chk(colValid === 1'b1, {req, " valid"}, int'(colValid), 1);
        chk(colOut === expCol(s, k, len, ip), {req, " col"}, int'(colOut), int'(expCol(s, k, len, ip)));
        chk(lastBeat === ((len != 0) && (k == n - 1)), {req, " R10 last"}, int'(lastBeat),
            int'((len != 0) && (k == n - 1)));
        if (g < gap) tick();
      end
      advance = 1'b1;
      tick();
      advance = 1'b0;
    end
    if (len == 0) begin
      chk(colValid === 1'b1, "R8 page still running", int'(colValid), 1);
      terminate = 1'b1;
      tick();
      terminate = 1'b0;
    end
    chk(colValid === 1'b0, {req, " R10 ended"}, int'(colValid), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick();
    tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk(colValid === 1'b0, "R1 valid", int'(colValid), 0);
    chk(lastBeat === 1'b0, "R1 last", int'(lastBeat), 0);
    chk(modeErr === 1'b0, "R1 err", int'(modeErr), 0);
    chk(casLat === 2'd2, "R1 cas", int'(casLat), 2);
    runBurst(8'h37, 1'b0, 0, "R1 default length one");

    // R5 sequential length 8 mid-block
    loadMode(12'h023);
    chk(casLat === 2'd2, "R2 cas two", int'(casLat), 2);
    runBurst(8'h2D, 1'b0, 0, "R5 seq8");
    loadMode(12'h031);
    chk(casLat === 2'd3, "R2 cas three", int'(casLat), 3);
    runBurst(8'hC3, 1'b0, 0, "R5 seq2");
    loadMode(12'h022);
    runBurst(8'h7E, 1'b0, 2, "R5 seq4");

    // R6 interleaved
    loadMode(12'h02B);
    runBurst(8'h2D, 1'b0, 0, "R6 int8");
    loadMode(12'h02A);
    runBurst(8'h93, 1'b0, 0, "R6 int4");

    // R7 length one ignores order bit
    loadMode(12'h028);
    runBurst(8'h55, 1'b0, 0, "R7 len1");

    // R8 full page wraps 255 -> 0
    loadMode(12'h037);
    runBurst(8'hF9, 1'b0, 1, "R8 page");

    // R3 illegal loads keep old settings
    loadMode(12'h034);
    chk(modeErr === 1'b1, "R3 err reserved len", int'(modeErr), 1);
    chk(casLat === 2'd3, "R3 cas kept", int'(casLat), 3);
    loadMode(12'h02F);
    chk(modeErr === 1'b1, "R3 err page interleave", int'(modeErr), 1);
    runBurst(8'hFE, 1'b0, 0, "R3 still page");
    loadMode(12'h423);
    loadMode(12'h0A3);
    loadMode(12'h053);
    runBurst(8'hFE, 1'b0, 0, "R3 settings unchanged");
    chk(modeErr === 1'b1, "R3 sticky", int'(modeErr), 1);

    // R9 single writes
    loadMode(12'h223);
    runBurst(8'h4A, 1'b1, 0, "R9 write single");
    runBurst(8'h4A, 1'b0, 0, "R9 read full length");

    // R4 abort mid-burst
    loadMode(12'h022);
    cmdStart = 1'b1; cmdCol = 8'h10; cmdWrite = 1'b0;
    tick();
    cmdStart = 1'b0;
    advance = 1'b1;
    tick();
    advance = 1'b0;
    chk(colOut === 8'h11, "R4 pre-abort beat", int'(colOut), 8'h11);
    runBurst(8'h66, 1'b0, 0, "R4 restart");

    // R11 hold while idle
    cmdStart = 1'b1; cmdCol = 8'h21;
    tick();
    cmdStart = 1'b0;
    repeat (3) tick();
    chk(colOut === 8'h21 && colValid === 1'b1, "R11 hold", int'(colOut), 8'h21);

    // R10 back-to-back: advance on last with new command
    advance = 1'b1; tick();
    advance = 1'b1; tick();
    advance = 1'b1; tick();
    chk(lastBeat === 1'b1 && colOut === 8'h20, "R10 on last", int'(colOut), 8'h20);
    cmdStart = 1'b1; cmdCol = 8'hA5;
    tick();
    cmdStart = 1'b0; advance = 1'b0;
    chk(colValid === 1'b1 && colOut === 8'hA5, "R10 seamless start", int'(colOut), 8'hA5);
    chk(lastBeat === 1'b0, "R10 new burst not last", int'(lastBeat), 0);
    advance = 1'b1; tick(); advance = 1'b0;
    chk(colOut === 8'hA6, "R10 new burst second beat", int'(colOut), 8'hA6);
    terminate = 1'b1; tick(); terminate = 1'b0;
    chk(colValid === 1'b0, "R8 terminate fixed burst", int'(colValid), 0);

    // random mixes
    for (int i = 0; i < 60; i++) begin
      logic [2:0] lc;
      logic [11:0] w;
      int sel;
      sel = int'($urandom_range(4, 0));
      lc = (sel == 4) ? 3'b111 : 3'(sel);
      w = '0;
      w[2:0] = lc;
      w[3] = (lc == 3'b111) ? 1'b0 : 1'($urandom_range(1, 0));
      w[6:4] = $urandom_range(1, 0) ? 3'b011 : 3'b010;
      w[9] = 1'($urandom_range(1, 0));
      loadMode(w);
      chk(casLat === mCas, "R2 random cas", int'(casLat), int'(mCas));
      runBurst(8'($urandom_range(255, 0)), 1'($urandom_range(1, 0)), 2, "R5 R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule